// File: doc/BRIEF.md
# Staged Fractional Divide Word Registers

This block keeps the divide setting of two synthesizer channels, a main channel and an auxiliary channel. Each setting is a 9-bit unsigned integer divider plus a signed fractional dividend. Register writes arrive from a serial loader as one-cycle strobes that carry a small address and a data word. Most writes only fill holding (shadow) registers. Each channel exposes an active pair that changes in a single clock edge, and only when the write that closes that channel's loading sequence arrives. This way a downstream delta-sigma modulator never sees a divider from one setting combined with a dividend from another.

Which write closes the sequence depends on two mode inputs. In fractional operation the main channel's upper dividend register is the trigger. When the wide (18-bit) dividend mode is selected, the main dividend is assembled from that upper 10-bit word and a previously written 8-bit lower word. In narrow (10-bit) mode the upper word alone is sign-extended. The auxiliary channel is always narrow, and its dividend register is its trigger. In integer operation the divider write itself takes effect at once and the dividend is zero. A one-cycle pulse per channel marks every change of its active pair.

Top module: `frac_divword_bank`

## Requirements
- R1: After a clock edge with `rst` high, all active dividers and dividends read zero and both update pulses are low.
- R2: Address encoding when `wr_en` is high: 0 = main divider (data[8:0]), 1 = main dividend low word (data[7:0]), 2 = main dividend high word (data[9:0]), 3 = auxiliary divider (data[8:0]), 4 = auxiliary dividend (data[9:0]). Addresses 5 to 15, and any cycle with `wr_en` low, change no output.
- R3: In fractional mode (`int_mode`=0), writes to addresses 0, 1 and 3 change no active output and raise no pulse.
- R4: In fractional mode with `main_wide`=1, a write to address 2 makes `main_frac` = {data[9:0], last low word} and `main_div` = the last main divider written, visible after that edge.
- R5: In fractional mode with `main_wide`=0, a write to address 2 makes `main_frac` = data[9:0] sign-extended to 18 bits (bit 9 is the sign), ignoring the low word, and loads `main_div` from the last main divider written.
- R6: In fractional mode, a write to address 4 makes `aux_frac` = data[9:0] sign-extended to 18 bits and `aux_div` = the last auxiliary divider written.
- R7: On a fractional commit, a staged divider below 6 becomes 6 and one above 505 becomes 505. Values in between pass unchanged.
- R8: In integer mode (`int_mode`=1), a write to address 0 (or 3) makes the main (or auxiliary) divider equal data[8:0] at that edge and its dividend zero. Writes to addresses 2 and 4 change nothing. The divider written in integer mode is also kept as the staged value for a later fractional commit.
- R9: A channel's update pulse is high for exactly the cycle after each of its commits and low otherwise. A commit on one channel never pulses or changes the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe from the serial loader |
| wr_addr | input | 4 | Register select |
| wr_data | input | 10 | Write data word |
| main_wide | input | 1 | Main dividend width: 1 = 18-bit, 0 = 10-bit |
| int_mode | input | 1 | 1 = integer divide, 0 = fractional divide |
| main_div | output | 9 | Active main integer divider |
| main_frac | output | 18 | Active main signed dividend |
| main_upd | output | 1 | Main active-value change pulse |
| aux_div | output | 9 | Active auxiliary integer divider |
| aux_frac | output | 18 | Active auxiliary signed dividend, sign-extended |
| aux_upd | output | 1 | Auxiliary active-value change pulse |

## Verification
The hardest situation to reach is a commit whose staged contents were written under different mode settings. Examples are a divider written in integer mode and committed later in fractional mode, or a low word left over from a wide-mode sequence at a narrow-mode commit. Fixed directed sequences rarely produce these. The random phase therefore switches `int_mode` and `main_wide` freely between individual writes, and it draws addresses over the full 4-bit space, so staged values cross mode changes many times. Directed writes cover the clamp limits and the most negative and most positive dividends.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    localparam int DIV_W  = 9;
    localparam int HI_W   = 10;
    localparam int LO_W   = 8;
    localparam int FRAC_W = HI_W + LO_W;
    localparam int ADDR_W = 4;
    localparam int DATA_W = (DIV_W > HI_W) ? ((DIV_W > LO_W) ? DIV_W : LO_W)
                                           : ((HI_W > LO_W) ? HI_W : LO_W);

    typedef logic [DIV_W-1:0]  div_t;
    typedef logic [FRAC_W-1:0] frac_t;
    typedef logic [HI_W-1:0]   hi_t;
    typedef logic [LO_W-1:0]   lo_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MAIN_DIV  = 4'd0,
        SEL_MAIN_LO   = 4'd1,
        SEL_MAIN_HI   = 4'd2,
        SEL_AUX_DIV   = 4'd3,
        SEL_AUX_FRAC  = 4'd4
    } reg_sel_e;

    typedef struct packed {
        logic mdiv;
        logic mlo;
        logic mhi;
        logic adiv;
        logic afrac;
    } wr_strobe_t;

    function automatic div_t clamp_div(div_t v, div_t lo, div_t hi);
        if (v < lo)      return lo;
        else if (v > hi) return hi;
        else             return v;
    endfunction

    function automatic frac_t sext_hi(hi_t h);
        return {{LO_W{h[HI_W-1]}}, h};
    endfunction

    function automatic frac_t join_words(hi_t h, lo_t l);
        return {h, l};
    endfunction

endpackage

// File: rtl/sdw_decode.sv
module sdw_decode
    import sdw_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_strobe_t        stb
);

    always_comb begin
        stb = '0;
        if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                SEL_MAIN_DIV: stb.mdiv  = 1'b1;
                SEL_MAIN_LO:  stb.mlo   = 1'b1;
                SEL_MAIN_HI:  stb.mhi   = 1'b1;
                SEL_AUX_DIV:  stb.adiv  = 1'b1;
                SEL_AUX_FRAC: stb.afrac = 1'b1;
                default:      stb       = '0;
            endcase
        end
    end

endmodule

// File: rtl/sdw_channel.sv
module sdw_channel
    import sdw_pkg::*;
#(
    parameter bit HAS_LO   = 1'b1,
    parameter int FRAC_MIN = 6,
    parameter int FRAC_MAX = 505
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              div_we,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wide,
    input  logic              int_mode,
    output div_t              act_div,
    output frac_t             act_frac,
    output logic              upd
);

    localparam div_t LIM_LO = div_t'(FRAC_MIN);
    localparam div_t LIM_HI = div_t'(FRAC_MAX);

    div_t  shadow_div_q;
    lo_t   lo_word;
    logic  wide_sel;
    hi_t   hi_word;
    frac_t frac_next;
    div_t  div_clamped;
    logic  commit_int;
    logic  commit_frac;

    generate
        if (HAS_LO) begin : g_lo
            lo_t shadow_lo_q;
            always_ff @(posedge clk) begin
                if (rst)        shadow_lo_q <= '0;
                else if (lo_we) shadow_lo_q <= wr_data[LO_W-1:0];
            end
            assign lo_word  = shadow_lo_q;
            assign wide_sel = wide;
        end else begin : g_nolo
            logic unused_lo_inputs;
            assign unused_lo_inputs = &{1'b0, lo_we, wide};
            assign lo_word  = '0;
            assign wide_sel = 1'b0;
        end
    endgenerate

    always_comb begin
        hi_word     = wr_data[HI_W-1:0];
        frac_next   = wide_sel ? join_words(hi_word, lo_word) : sext_hi(hi_word);
        div_clamped = clamp_div(shadow_div_q, LIM_LO, LIM_HI);
        commit_int  = div_we & int_mode;
        commit_frac = hi_we & ~int_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_div_q <= '0;
            act_div      <= '0;
            act_frac     <= '0;
            upd          <= 1'b0;
        end else begin
            upd <= commit_int | commit_frac;
            if (div_we) shadow_div_q <= wr_data[DIV_W-1:0];
            if (commit_int) begin
                act_div  <= wr_data[DIV_W-1:0];
                act_frac <= '0;
            end else if (commit_frac) begin
                act_div  <= div_clamped;
                act_frac <= frac_next;
            end
        end
    end

endmodule

// File: rtl/frac_divword_bank.sv
module frac_divword_bank
    import sdw_pkg::*;
#(
    parameter int FRAC_MIN = 6,
    parameter int FRAC_MAX = 505
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              main_wide,
    input  logic              int_mode,
    output logic [DIV_W-1:0]  main_div,
    output logic [FRAC_W-1:0] main_frac,
    output logic              main_upd,
    output logic [DIV_W-1:0]  aux_div,
    output logic [FRAC_W-1:0] aux_frac,
    output logic              aux_upd
);

    wr_strobe_t stb;

    sdw_decode u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .stb     (stb)
    );

    sdw_channel #(
        .HAS_LO   (1'b1),
        .FRAC_MIN (FRAC_MIN),
        .FRAC_MAX (FRAC_MAX)
    ) u_main (
        .clk      (clk),
        .rst      (rst),
        .div_we   (stb.mdiv),
        .lo_we    (stb.mlo),
        .hi_we    (stb.mhi),
        .wr_data  (wr_data),
        .wide     (main_wide),
        .int_mode (int_mode),
        .act_div  (main_div),
        .act_frac (main_frac),
        .upd      (main_upd)
    );

    sdw_channel #(
        .HAS_LO   (1'b0),
        .FRAC_MIN (FRAC_MIN),
        .FRAC_MAX (FRAC_MAX)
    ) u_aux (
        .clk      (clk),
        .rst      (rst),
        .div_we   (stb.adiv),
        .lo_we    (1'b0),
        .hi_we    (stb.afrac),
        .wr_data  (wr_data),
        .wide     (1'b0),
        .int_mode (int_mode),
        .act_div  (aux_div),
        .act_frac (aux_frac),
        .upd      (aux_upd)
    );

endmodule

// File: rtl/frac_divword_bank_chk.sv
module frac_divword_bank_chk
    import sdw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              main_wide,
    input logic              int_mode,
    input logic [DIV_W-1:0]  main_div,
    input logic [FRAC_W-1:0] main_frac,
    input logic              main_upd,
    input logic [DIV_W-1:0]  aux_div,
    input logic [FRAC_W-1:0] aux_frac,
    input logic              aux_upd
);

    logic unused_chk;
    assign unused_chk = &{1'b0, wr_data};

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (main_div == '0 && main_frac == '0 && aux_div == '0 &&
                 aux_frac == '0 && !main_upd && !aux_upd));

    // R3
    main_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !main_upd |-> ($stable(main_div) && $stable(main_frac)));

    // R3
    aux_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !aux_upd |-> ($stable(aux_div) && $stable(aux_frac)));

    // R9
    main_cause_chk: assert property (@(posedge clk) disable iff (rst)
        main_upd |-> $past(wr_en && ((wr_addr == 4'd0 && int_mode) ||
                                     (wr_addr == 4'd2 && !int_mode))));

    // R9
    aux_cause_chk: assert property (@(posedge clk) disable iff (rst)
        aux_upd |-> $past(wr_en && ((wr_addr == 4'd3 && int_mode) ||
                                    (wr_addr == 4'd4 && !int_mode))));

    // R7
    main_range_chk: assert property (@(posedge clk) disable iff (rst)
        (main_upd && !$past(int_mode)) |-> (main_div >= 9'd6 && main_div <= 9'd505));

    // R7
    aux_range_chk: assert property (@(posedge clk) disable iff (rst)
        (aux_upd && !$past(int_mode)) |-> (aux_div >= 9'd6 && aux_div <= 9'd505));

    // R8
    int_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (main_upd && $past(int_mode)) |-> (main_frac == '0));

    // R5
    narrow_sext_chk: assert property (@(posedge clk) disable iff (rst)
        (main_upd && $past(!main_wide && !int_mode)) |->
            (main_frac[FRAC_W-1:HI_W-1] == '0 || &main_frac[FRAC_W-1:HI_W-1]));

    // R6
    aux_sext_chk: assert property (@(posedge clk) disable iff (rst)
        aux_upd |-> (aux_frac[FRAC_W-1:HI_W-1] == '0 || &aux_frac[FRAC_W-1:HI_W-1]));

endmodule

bind frac_divword_bank frac_divword_bank_chk chk_i (.*);

// File: tb/frac_divword_bank_tb_top.sv
module frac_divword_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [9:0]  wr_data = '0;
    logic        main_wide = 1'b1;
    logic        int_mode = 1'b0;
    logic [8:0]  main_div;
    logic [17:0] main_frac;
    logic        main_upd;
    logic [8:0]  aux_div;
    logic [17:0] aux_frac;
    logic        aux_upd;

    int checks = 0;
    int errors = 0;

    logic [8:0]  m_sh_div, a_sh_div;
    logic [7:0]  m_sh_lo;
    logic [8:0]  e_mdiv, e_adiv;
    logic [17:0] e_mfrac, e_afrac;
    logic        e_mupd, e_aupd;
    string       tag;

    always #4 clk = ~clk;

    frac_divword_bank dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .main_wide(main_wide), .int_mode(int_mode),
        .main_div(main_div), .main_frac(main_frac), .main_upd(main_upd),
        .aux_div(aux_div), .aux_frac(aux_frac), .aux_upd(aux_upd)
    );

    function automatic logic [17:0] sx10(logic [9:0] v);
        return {{8{v[9]}}, v};
    endfunction

    function automatic logic [8:0] lim(logic [8:0] v);
        if (v < 9'd6) return 9'd6;
        if (v > 9'd505) return 9'd505;
        return v;
    endfunction

    task automatic check(string req, string what, logic [17:0] act, logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check(req, "main_div", 18'(main_div), 18'(e_mdiv));
        check(req, "main_frac", main_frac, e_mfrac);
        check(req, "main_upd", 18'(main_upd), 18'(e_mupd));
        check(req, "aux_div", 18'(aux_div), 18'(e_adiv));
        check(req, "aux_frac", aux_frac, e_afrac);
        check(req, "aux_upd", 18'(aux_upd), 18'(e_aupd));
    endtask

    task automatic model(logic en, logic [3:0] a, logic [9:0] d);
        e_mupd = 1'b0;
        e_aupd = 1'b0;
        tag = "R2";
        if (!en) return;
        case (a)
            4'd0: begin
                m_sh_div = d[8:0];
                if (int_mode) begin
                    e_mdiv = d[8:0]; e_mfrac = '0; e_mupd = 1'b1; tag = "R8";
                end else tag = "R3";
            end
            4'd1: begin m_sh_lo = d[7:0]; tag = "R3"; end
            4'd2: begin
                if (!int_mode) begin
                    e_mdiv  = lim(m_sh_div);
                    e_mfrac = main_wide ? {d, m_sh_lo} : sx10(d);
                    e_mupd  = 1'b1;
                    tag = main_wide ? "R4" : "R5";
                end else tag = "R8";
            end
            4'd3: begin
                a_sh_div = d[8:0];
                if (int_mode) begin
                    e_adiv = d[8:0]; e_afrac = '0; e_aupd = 1'b1; tag = "R8";
                end else tag = "R3";
            end
            4'd4: begin
                if (!int_mode) begin
                    e_adiv = lim(a_sh_div); e_afrac = sx10(d); e_aupd = 1'b1; tag = "R6";
                end else tag = "R8";
            end
            default: tag = "R2";
        endcase
    endtask

    // drive at a falling edge, compare at the next falling edge, then idle one cycle
    task automatic wr(logic en, logic [3:0] a, logic [9:0] d);
        wr_en = en; wr_addr = a; wr_data = d;
        @(negedge clk);
        model(en, a, d);
        check_all(tag);
        wr_en = 1'b0;
        @(negedge clk);
        e_mupd = 1'b0; e_aupd = 1'b0;
        check_all("R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_sh_div = '0; a_sh_div = '0; m_sh_lo = '0;
        e_mdiv = '0; e_adiv = '0; e_mfrac = '0; e_afrac = '0;
        e_mupd = 1'b0; e_aupd = 1'b0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check_all("R1");
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // wide fractional sequence (R4), staged writes hold (R3)
        int_mode = 1'b0; main_wide = 1'b1;
        wr(1'b1, 4'd0, 10'd100);
        wr(1'b1, 4'd1, 10'h0A5);
        wr(1'b1, 4'd2, 10'h3C1);
        // narrow most negative and most positive (R5)
        main_wide = 1'b0;
        wr(1'b1, 4'd2, 10'h200);
        wr(1'b1, 4'd2, 10'h1FF);
        // clamp low and high (R7)
        wr(1'b1, 4'd0, 10'd2);
        wr(1'b1, 4'd2, 10'd5);
        wr(1'b1, 4'd0, 10'd510);
        wr(1'b1, 4'd2, 10'd7);
        wr(1'b1, 4'd0, 10'd6);
        wr(1'b1, 4'd2, 10'd8);
        // aux sequence (R6)
        wr(1'b1, 4'd3, 10'd300);
        wr(1'b1, 4'd4, 10'h301);
        wr(1'b1, 4'd3, 10'd511);
        wr(1'b1, 4'd4, 10'h001);
        // unused addresses and idle strobe (R2)
        wr(1'b1, 4'd5, 10'h3FF);
        wr(1'b1, 4'd15, 10'h3FF);
        wr(1'b0, 4'd2, 10'h155);
        // integer mode (R8)
        int_mode = 1'b1;
        wr(1'b1, 4'd0, 10'd0);
        wr(1'b1, 4'd2, 10'h2AA);
        wr(1'b1, 4'd3, 10'd511);
        wr(1'b1, 4'd4, 10'h123);
        wr(1'b1, 4'd0, 10'd3);
        int_mode = 1'b0; main_wide = 1'b1;
        wr(1'b1, 4'd2, 10'h011);

        // random phase with modes switched between writes
        for (int i = 0; i < 600; i++) begin
            int_mode  = ($urandom % 4) == 0;
            main_wide = $urandom % 2;
            wr(($urandom % 8) != 0, 4'($urandom % 7 == 6 ? $urandom : $urandom % 5),
               10'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule